// File: doc/BRIEF.md
# CAN Receiver Status Flag Register

This block keeps the eight sticky event flags of a CAN controller's receive side and turns them into four interrupt requests. Each flag is raised from a condition that the surrounding controller supplies: a bus-activity strobe seen during sleep, the receive and transmit error counts, a bus-off level, an overrun strobe and a receive-buffer-full strobe. The warning, error-passive and bus-off conditions are decoded here from the two error counts and the bus-off input.

Software reads the flags and clears them with a write-one-to-clear access on a small register bus. It also programs an 8-bit enable mask at a second address. A clear is only honoured once the condition that raised the flag has gone away. The two warning flags are held off while a more serious error flag (either error-passive or bus-off) is already set. A hard reset (asynchronous, active low) and a soft reset (synchronous) both return every flag and every enable bit to zero.

Top module: `can_rx_flag_reg`

## Requirements
- R1: Reading address 0 returns the flags at these bit positions: 7 wake-up, 6 receive warning, 5 transmit warning, 4 receive error-passive, 3 transmit error-passive, 2 bus-off, 1 overrun, 0 receive buffer full. With `reg_rd` low, `reg_rdata` is 0.
- R2: A write to address 0 clears each flag whose data bit is 1, one cycle later, provided its set condition is absent in that cycle. Data bits that are 0 leave their flags unchanged.
- R3: A flag whose set condition is present in the cycle of a clear write stays set.
- R4: While `rst_n` is low, all flags and all enable bits read as 0.
- R5: A cycle with `soft_rst` high clears all flags and all enable bits, and this takes priority over any set condition.
- R6: The wake-up flag is set when `bus_act` is high while `sleep_mode` is high. Bus activity outside sleep has no effect.
- R7: The receive warning flag is set when the receive count is in 97..127 and flags 4, 3 and 2 are all clear.
- R8: The transmit warning flag is set when the transmit count is in 97..127, with the same gating as R7.
- R9: The receive error-passive flag is set when the receive count is 128 or more. The transmit error-passive flag is set when the transmit count is 128 or more and `bus_off` is low. The bus-off flag is set while `bus_off` is high.
- R10: The overrun flag is set by `ovr_stb`. The receive buffer full flag is set by `rxf_stb`.
- R11: A write to address 1 loads the enable mask, which reads back unchanged at address 1.
- R12: `irq_wake` is flag 7 AND enable 7. `irq_err` is high when any of flags 6..2 is set with its enable bit. `irq_ovr` uses bit 1 and `irq_rx` uses bit 0 in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| sleep_mode | input | 1 | Controller is in sleep |
| bus_act | input | 1 | Bus activity strobe |
| rx_err_cnt | input | CNT_W (8) | Receive error count |
| tx_err_cnt | input | CNT_W (8) | Transmit error count |
| bus_off | input | 1 | Bus-off condition |
| ovr_stb | input | 1 | Receive overrun strobe |
| rxf_stb | input | 1 | Receive buffer full strobe |
| reg_addr | input | 1 | 0 = flags, 1 = enable mask |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| irq_wake | output | 1 | Wake-up interrupt |
| irq_err | output | 1 | Error interrupt |
| irq_ovr | output | 1 | Overrun interrupt |
| irq_rx | output | 1 | Receive interrupt |

## Verification
The bench builds the block with its default 8-bit counters, so the thresholds 96, 97, 127 and 128 can all be driven directly, and so can the region above 128 where the transmit error-passive flag competes with bus-off. With that width, the warning windows can be probed at both edges. The gating of the warning flags by an already-set error flag can be checked in both directions: it blocks a new set, and it lets a clear go through while the count is still inside the window.

// File: rtl/can_flag_pkg.sv
package can_flag_pkg;
  localparam int FLAG_N  = 8;
  localparam int B_WAKE  = 7;
  localparam int B_RWARN = 6;
  localparam int B_TWARN = 5;
  localparam int B_RPASS = 4;
  localparam int B_TPASS = 3;
  localparam int B_BOFF  = 2;
  localparam int B_OVR   = 1;
  localparam int B_RXF   = 0;
  typedef logic [FLAG_N-1:0] flag_vec_t;
endpackage

// File: rtl/can_flag_cond.sv
module can_flag_cond
  import can_flag_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int WARN_LIM    = 96,
  parameter int PASSIVE_LIM = 128
) (
  input  logic             sleep_mode,
  input  logic             bus_act,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic             bus_off,
  input  logic             ovr_stb,
  input  logic             rxf_stb,
  input  flag_vec_t        flags_q,
  output flag_vec_t        set_o
);
  localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_LIM);
  localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASSIVE_LIM);

  logic worse_held;
  logic rx_warn_win, tx_warn_win;

  always_comb begin
    // Warning flags are held off while a more serious flag is pending.
    worse_held  = flags_q[B_RPASS] | flags_q[B_TPASS] | flags_q[B_BOFF];
    rx_warn_win = (rx_cnt > WARN_V) && (rx_cnt < PASS_V);
    tx_warn_win = (tx_cnt > WARN_V) && (tx_cnt < PASS_V);

    set_o          = '0;
    set_o[B_WAKE]  = sleep_mode & bus_act;
    set_o[B_RWARN] = rx_warn_win & ~worse_held;
    set_o[B_TWARN] = tx_warn_win & ~worse_held;
    set_o[B_RPASS] = (rx_cnt >= PASS_V);
    set_o[B_TPASS] = (tx_cnt >= PASS_V) & ~bus_off;
    set_o[B_BOFF]  = bus_off;
    set_o[B_OVR]   = ovr_stb;
    set_o[B_RXF]   = rxf_stb;
  end
endmodule

// File: rtl/can_flag_cell.sv
module can_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic srst_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;

  always_comb begin
    if (srst_i)       q_d = 1'b0;
    else if (set_i)   q_d = 1'b1;
    else if (clr_i)   q_d = 1'b0;
    else              q_d = q_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_d;
  end

  p_set_beats_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !srst_i) |=> q_o);
  p_clear_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i && !srst_i) |=> !q_o);
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i && !srst_i) |=> $stable(q_o));
  p_soft_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    srst_i |=> !q_o);
endmodule

// File: rtl/can_flag_irq.sv
module can_flag_irq
  import can_flag_pkg::*;
(
  input  flag_vec_t flags_q,
  input  flag_vec_t en_q,
  output logic      irq_wake,
  output logic      irq_err,
  output logic      irq_ovr,
  output logic      irq_rx
);
  flag_vec_t live;

  always_comb begin
    live     = flags_q & en_q;
    irq_wake = live[B_WAKE];
    irq_err  = |live[B_RWARN:B_BOFF];
    irq_ovr  = live[B_OVR];
    irq_rx   = live[B_RXF];
  end
endmodule

// File: rtl/can_rx_flag_reg.sv
module can_rx_flag_reg
  import can_flag_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int WARN_LIM    = 96,
  parameter int PASSIVE_LIM = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             sleep_mode,
  input  logic             bus_act,
  input  logic [CNT_W-1:0] rx_err_cnt,
  input  logic [CNT_W-1:0] tx_err_cnt,
  input  logic             bus_off,
  input  logic             ovr_stb,
  input  logic             rxf_stb,
  input  logic             reg_addr,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq_wake,
  output logic             irq_err,
  output logic             irq_ovr,
  output logic             irq_rx
);
  flag_vec_t flags_q, set_v, clr_v;
  flag_vec_t en_q, en_d;
  logic      wr_flags, wr_en;

  always_comb begin
    wr_flags = reg_wr & ~reg_addr;
    wr_en    = reg_wr &  reg_addr;
    clr_v    = wr_flags ? flag_vec_t'(reg_wdata) : '0;
  end

  can_flag_cond #(
    .CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .PASSIVE_LIM(PASSIVE_LIM)
  ) cond_i (
    .sleep_mode(sleep_mode), .bus_act(bus_act),
    .rx_cnt(rx_err_cnt), .tx_cnt(tx_err_cnt), .bus_off(bus_off),
    .ovr_stb(ovr_stb), .rxf_stb(rxf_stb),
    .flags_q(flags_q), .set_o(set_v)
  );

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    can_flag_cell cell_i (
      .clk(clk), .rst_n(rst_n), .srst_i(soft_rst),
      .set_i(set_v[g]), .clr_i(clr_v[g]), .q_o(flags_q[g])
    );
  end

  // Enable mask: next state and register kept apart.
  always_comb begin
    if (soft_rst)    en_d = '0;
    else if (wr_en)  en_d = flag_vec_t'(reg_wdata);
    else             en_d = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  always_comb begin
    if (!reg_rd)        reg_rdata = '0;
    else if (reg_addr)  reg_rdata = en_q;
    else                reg_rdata = flags_q;
  end

  can_flag_irq irq_i (
    .flags_q(flags_q), .en_q(en_q),
    .irq_wake(irq_wake), .irq_err(irq_err), .irq_ovr(irq_ovr), .irq_rx(irq_rx)
  );

  p_rwarn_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[B_RWARN]) |-> $past(flags_q[B_RPASS:B_BOFF] == 3'b000));
  p_twarn_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[B_TWARN]) |-> $past(flags_q[B_RPASS:B_BOFF] == 3'b000));
  p_en_soft_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (en_q == '0));
  p_en_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !soft_rst) |=> (en_q == $past(reg_wdata)));
  p_wake_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[B_WAKE] |-> !irq_wake);
  p_rx_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[B_RXF] |-> !irq_rx);
endmodule

// File: tb/can_rx_flag_reg_tb_top.sv
`timescale 1ns/1ps
module can_rx_flag_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, soft_rst, sleep_mode, bus_act, bus_off, ovr_stb, rxf_stb;
  logic [7:0] rx_err_cnt, tx_err_cnt;
  logic       reg_addr, reg_rd, reg_wr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq_wake, irq_err, irq_ovr, irq_rx;
  int         n_chk = 0, n_bad = 0;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  can_rx_flag_reg dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .sleep_mode(sleep_mode), .bus_act(bus_act),
    .rx_err_cnt(rx_err_cnt), .tx_err_cnt(tx_err_cnt), .bus_off(bus_off),
    .ovr_stb(ovr_stb), .rxf_stb(rxf_stb),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_wake(irq_wake), .irq_err(irq_err), .irq_ovr(irq_ovr), .irq_rx(irq_rx)
  );

  // {sleep, act, rec[8], tec[8], boff, ovr, rxf, wr, addr, wdata[8], expected flags[8]}
  localparam int NV = 26;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0,1'b0,8'd50 ,8'd0  ,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h00}, // R7 below window
    {1'b0,1'b0,8'd97 ,8'd0  ,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h40}, // R7 low edge, R1 bit 6
    {1'b0,1'b0,8'd96 ,8'd0  ,1'b0,1'b0,1'b0,1'b1,1'b0,8'h40,8'h00}, // R2 clear
    {1'b0,1'b0,8'd127,8'd0  ,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h40}, // R7 high edge
    {1'b0,1'b0,8'd127,8'd0  ,1'b0,1'b0,1'b0,1'b1,1'b0,8'h40,8'h40}, // R3 clear refused
    {1'b0,1'b0,8'd128,8'd0  ,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h50}, // R9 rx passive
    {1'b0,1'b0,8'd100,8'd0  ,1'b0,1'b0,1'b0,1'b1,1'b0,8'h50,8'h00}, // R7 gated clear
    {1'b0,1'b0,8'd100,8'd0  ,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h40}, // R7
    {1'b0,1'b0,8'd0  ,8'd0  ,1'b0,1'b0,1'b0,1'b1,1'b0,8'h40,8'h00}, // R2
    {1'b0,1'b0,8'd0  ,8'd97 ,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h20}, // R8
    {1'b0,1'b0,8'd0  ,8'd128,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h28}, // R9 tx passive
    {1'b0,1'b0,8'd0  ,8'd128,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,8'h2C}, // R9 bus-off
    {1'b0,1'b0,8'd0  ,8'd0  ,1'b0,1'b0,1'b0,1'b1,1'b0,8'hFF,8'h00}, // R2 clear all
    {1'b0,1'b0,8'd0  ,8'd110,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,8'h24}, // R8, R9
    {1'b0,1'b0,8'd0  ,8'd110,1'b1,1'b0,1'b0,1'b1,1'b0,8'h20,8'h04}, // R8 gated clear, R3
    {1'b0,1'b0,8'd0  ,8'd0  ,1'b0,1'b0,1'b0,1'b1,1'b0,8'h04,8'h00}, // R2
    {1'b0,1'b1,8'd0  ,8'd0  ,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h00}, // R6 awake
    {1'b1,1'b0,8'd0  ,8'd0  ,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h00}, // R6 quiet
    {1'b1,1'b1,8'd0  ,8'd0  ,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h80}, // R6
    {1'b1,1'b1,8'd0  ,8'd0  ,1'b0,1'b0,1'b0,1'b1,1'b0,8'h80,8'h80}, // R3
    {1'b0,1'b0,8'd0  ,8'd0  ,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,8'h80}, // R2 zero write
    {1'b0,1'b0,8'd0  ,8'd0  ,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,8'h82}, // R10 overrun
    {1'b0,1'b0,8'd0  ,8'd0  ,1'b0,1'b0,1'b1,1'b1,1'b0,8'h82,8'h01}, // R10 rx full, R2
    {1'b0,1'b0,8'd0  ,8'd0  ,1'b0,1'b0,1'b1,1'b1,1'b0,8'h01,8'h01}, // R3
    {1'b0,1'b0,8'd0  ,8'd0  ,1'b0,1'b0,1'b0,1'b1,1'b0,8'h01,8'h00}, // R2
    {1'b0,1'b0,8'd0  ,8'd0  ,1'b0,1'b0,1'b0,1'b1,1'b1,8'h5A,8'h00}  // R11 write mask
  };

  task automatic idle();
    soft_rst = 0; sleep_mode = 0; bus_act = 0; bus_off = 0; ovr_stb = 0; rxf_stb = 0;
    rx_err_cnt = 0; tx_err_cnt = 0; reg_addr = 0; reg_rd = 1; reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // One clock edge; inputs return to idle just after it.
  task automatic tick();
    @(posedge clk); #1; idle();
  endtask

  task automatic write(input logic a, input logic [7:0] d);
    reg_addr = a; reg_wr = 1; reg_wdata = d; tick();
  endtask

  task automatic peek(input logic a, output logic [7:0] d);
    reg_addr = a; #0.5; d = reg_rdata; reg_addr = 0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    logic [7:0] v;
    idle(); rst_n = 0;
    #5;
    peek(0, v); chk("R4 reset flags", v, 8'h00);
    peek(1, v); chk("R4 reset enable", v, 8'h00);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;

    for (int i = 0; i < NV; i++) begin
      sleep_mode = VEC[i][38]; bus_act = VEC[i][37];
      rx_err_cnt = VEC[i][36:29]; tx_err_cnt = VEC[i][28:21];
      bus_off = VEC[i][20]; ovr_stb = VEC[i][19]; rxf_stb = VEC[i][18];
      reg_wr = VEC[i][17]; reg_addr = VEC[i][16]; reg_wdata = VEC[i][15:8];
      tick();
      peek(0, v); chk($sformatf("R1 vector %0d", i), v, VEC[i][7:0]);
    end

    peek(1, v); chk("R11 mask readback", v, 8'h5A);
    reg_rd = 0; #0.5; chk("R1 rdata idle", reg_rdata, 8'h00); reg_rd = 1;

    write(1, 8'hC3);
    peek(1, v); chk("R11 mask readback", v, 8'hC3);
    sleep_mode = 1; bus_act = 1; ovr_stb = 1; rxf_stb = 1; rx_err_cnt = 8'd100;
    tick();
    peek(0, v); chk("R12 flags", v, 8'hC3);
    chk("R12 irq all", {4'h0, irq_wake, irq_err, irq_ovr, irq_rx}, 8'h0F);
    write(1, 8'h3C);
    chk("R12 irq masked", {4'h0, irq_wake, irq_err, irq_ovr, irq_rx}, 8'h00);
    rx_err_cnt = 8'd130; tick();
    peek(0, v); chk("R9 rx passive", v, 8'hD3);
    chk("R12 irq err", {4'h0, irq_wake, irq_err, irq_ovr, irq_rx}, 8'h04);

    soft_rst = 1; bus_off = 1; rxf_stb = 1; tick();
    peek(0, v); chk("R5 soft flags", v, 8'h00);
    peek(1, v); chk("R5 soft enable", v, 8'h00);
    chk("R5 irq quiet", {4'h0, irq_wake, irq_err, irq_ovr, irq_rx}, 8'h00);

    write(1, 8'h02);
    ovr_stb = 1; tick();
    chk("R12 irq ovr", {4'h0, irq_wake, irq_err, irq_ovr, irq_rx}, 8'h02);
    #0.5; rst_n = 0; #0.5;
    peek(0, v); chk("R4 hard flags", v, 8'h00);
    peek(1, v); chk("R4 hard enable", v, 8'h00);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;

    done = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
    end
  end
endmodule